// File: doc/BRIEF.md
# Host Attention and Port Controller

This block is the control front end that a host processor uses to start a network coprocessor. It brings four asynchronous controls into the system clock domain: a reset pin, a channel-attention strobe, a port-write strobe that has a 32-bit data bus with it, and a per-cycle transmit-clock tick. The reset pin takes effect only after it has been held long enough in both system clocks and transmit-clock ticks. From then on, the block holds the rest of the device in reset until the pin drops. After that it stays idle until the host gives an attention.

The first attention after any reset asks for initialization, starting from a fixed default address or from an address the host loaded earlier through the port. Every later attention asks for command execution. Each port command takes two strobes. The first strobe gives the low half of a command word and the second gives the high half. The four lowest bits of the word select an action and the bits above them give an address.

The block also turns each rising edge of an interrupt request from the rest of the device into one active edge on an interrupt pin whose polarity is selectable. The pin stays active until the host acknowledges.

Top module: `host_attn_ctrl`

## Requirements
- R1: A reset pin pulse that stays high for fewer than 5 system clocks after synchronization never asserts `dev_reset`, however many transmit ticks arrive.
- R2: `dev_reset` rises only after the synchronized reset pin has been high for at least 5 system clocks and has seen at least 4 `tx_tick` cycles. It falls within a few clocks of the pin going low.
- R3: While `dev_reset` is high, attention and port strobes are ignored and no request pulse is issued. After reset is released, no request appears until an attention arrives.
- R4: An attention event is taken on the falling edge of the synchronized attention input. Holding it high issues nothing.
- R5: The first attention after a hardware reset pulses `init_req` with `req_addr` = 0x00FFFFF6, unless a start address was loaded through the port since then.
- R6: Each attention after the one that produced the initialization request pulses `exec_req` and never `init_req`.
- R7: A port command needs two rising edges of the port strobe. The command word is {second strobe data[31:16], first strobe data[15:0]}, its bits [3:0] are the command code, and a single strobe alone has no effect.
- R8: Code 4'h2 loads the start address {word[31:4], 4'h0}, which the next initialization request carries. A hardware reset restores 0x00FFFFF6.
- R9: Code 4'h1 pulses `test_req` for one cycle with `test_addr` = {word[31:4], 4'h0}.
- R10: Code 4'h0 returns the block to waiting for a first attention, so the next attention initializes. It drops any pending request and keeps the loaded start address. All other codes have no effect.
- R11: While `core_busy` is high, attentions are held pending and merged. When busy drops, exactly one single-cycle request of the pending kind is issued. `init_req` and `exec_req` are never high together.
- R12: Each rising edge of `irq_req` makes `irq_out` go active (high when `irq_pol`=1, low when 0) until `irq_ack`. One edge arriving while the pin is active is queued and gives a new active edge after the acknowledge.
- R13: After `rst`, `irq_out` is inactive and `dev_reset`, `init_req`, `exec_req` and `test_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset of the block's registers |
| hw_reset_a | input | 1 | Asynchronous reset pin from the host |
| attn_a | input | 1 | Asynchronous channel-attention strobe |
| port_wr_a | input | 1 | Asynchronous port-write strobe |
| port_data | input | 32 | Port data bus, stable while the strobe is high |
| tx_tick | input | 1 | One system-clock-wide pulse per transmit-clock cycle |
| core_busy | input | 1 | Device core cannot take a new request yet |
| irq_req | input | 1 | Interrupt request from the device core |
| irq_ack | input | 1 | Host acknowledge of the interrupt |
| irq_pol | input | 1 | 1: active-high interrupt pin, 0: active-low |
| dev_reset | output | 1 | Device held in reset; current activity ends |
| init_req | output | 1 | One-cycle initialization request |
| exec_req | output | 1 | One-cycle command-execution request |
| req_addr | output | 32 | Start address with `init_req`, zero otherwise |
| test_req | output | 1 | One-cycle self-test request |
| test_addr | output | 32 | Address with `test_req` |
| irq_out | output | 1 | Interrupt pin |

## Verification
The checker watches these properties on every cycle:
- the two request kinds never overlap, and every request lasts a single cycle;
- no request appears while reset is held;
- `dev_reset` never rises before the synchronized pin has been high for the minimum count, and it drops after the pin falls;
- an acknowledge always leaves the interrupt pin inactive.

Other behaviour depends on history and only the bench's scenarios can show it:
- the transmit-tick minimum;
- which attention counts as first;
- how port words combine and which addresses they load;
- the effect of a software reset;
- merging of attentions under busy;
- the queued interrupt edge.

// File: rtl/hac_pkg.sv
package hac_pkg;
  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    PCMD_SOFT_RST  = 4'h0,
    PCMD_SELF_TEST = 4'h1,
    PCMD_SET_START = 4'h2
  } port_cmd_e;

  typedef enum logic [1:0] {
    REQ_NONE = 2'd0,
    REQ_INIT = 2'd1,
    REQ_EXEC = 2'd2
  } req_kind_e;
endpackage

// File: rtl/hac_sync.sv
module hac_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_a,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else if (s == 0) chain[s] <= d_a;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hac_reset_seq.sv
module hac_reset_seq #(
  parameter int SYS_CYC = 5,
  parameter int TX_CYC  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_sync,
  input  logic tx_tick,
  output logic dev_reset
);
  localparam int SW = $clog2(SYS_CYC + 1);
  localparam int TW = $clog2(TX_CYC + 1);

  logic [SW-1:0] sys_cnt;
  logic [TW-1:0] tx_cnt;
  logic          sys_done, tx_done;

  assign sys_done = (sys_cnt == SW'(SYS_CYC));
  assign tx_done  = (tx_cnt == TW'(TX_CYC));

  always_ff @(posedge clk) begin
    if (rst || !pin_sync) begin
      sys_cnt   <= '0;
      tx_cnt    <= '0;
      dev_reset <= 1'b0;
    end else begin
      if (!sys_done) sys_cnt <= sys_cnt + 1'b1;
      if (tx_tick && !tx_done) tx_cnt <= tx_cnt + 1'b1;
      dev_reset <= sys_done && tx_done;
    end
  end
endmodule

// File: rtl/hac_port_dec.sv
module hac_port_dec
  import hac_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_sync,
  input  logic [DW-1:0]     data,
  output logic              cmd_valid,
  output logic [CODE_W-1:0] cmd_code,
  output logic [DW-1:0]     cmd_addr
);
  localparam int HW = DW / 2;

  logic          wr_q, wr_rise, have_lo;
  logic [HW-1:0] lo_half;
  logic [DW-1:0] cmd_word;

  assign wr_rise = wr_sync && !wr_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_q      <= 1'b0;
      have_lo   <= 1'b0;
      lo_half   <= '0;
      cmd_word  <= '0;
      cmd_valid <= 1'b0;
    end else begin
      wr_q      <= wr_sync;
      cmd_valid <= 1'b0;
      if (wr_rise) begin
        if (!have_lo) begin
          lo_half <= data[HW-1:0];
          have_lo <= 1'b1;
        end else begin
          cmd_word  <= {data[DW-1:HW], lo_half};
          cmd_valid <= 1'b1;
          have_lo   <= 1'b0;
        end
      end
    end
  end

  assign cmd_code = cmd_word[CODE_W-1:0];
  assign cmd_addr = {cmd_word[DW-1:CODE_W], {CODE_W{1'b0}}};
endmodule

// File: rtl/hac_attn_seq.sv
module hac_attn_seq
  import hac_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          soft_rst,
  input  logic          attn_evt,
  input  logic          core_busy,
  input  logic [DW-1:0] start_addr,
  output logic          init_req,
  output logic          exec_req,
  output logic [DW-1:0] req_addr
);
  logic      init_done;
  req_kind_e pend_kind;
  req_kind_e kind_now;

  always_comb begin
    if (pend_kind != REQ_NONE) kind_now = pend_kind;
    else if (!init_done)       kind_now = REQ_INIT;
    else                       kind_now = REQ_EXEC;
  end

  always_ff @(posedge clk) begin
    if (rst || clr || soft_rst) begin
      init_done <= 1'b0;
      pend_kind <= REQ_NONE;
      init_req  <= 1'b0;
      exec_req  <= 1'b0;
      req_addr  <= '0;
    end else begin
      init_req <= 1'b0;
      exec_req <= 1'b0;
      req_addr <= '0;
      if (attn_evt || pend_kind != REQ_NONE) begin
        if (!core_busy) begin
          pend_kind <= REQ_NONE;
          if (kind_now == REQ_INIT) begin
            init_req  <= 1'b1;
            req_addr  <= start_addr;
            init_done <= 1'b1;
          end else begin
            exec_req <= 1'b1;
          end
        end else begin
          pend_kind <= kind_now;
        end
      end
    end
  end
endmodule

// File: rtl/hac_irq_gen.sv
module hac_irq_gen (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic irq_req,
  input  logic irq_ack,
  input  logic irq_pol,
  output logic irq_out
);
  logic req_q, rise, pend, again, pend_n, again_n;

  assign rise = irq_req && !req_q;

  always_comb begin
    if (irq_ack) begin
      pend_n  = 1'b0;
      again_n = again || rise;
    end else if (!pend) begin
      pend_n  = again || rise;
      again_n = again && rise;
    end else begin
      pend_n  = 1'b1;
      again_n = again || rise;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      req_q   <= 1'b0;
      pend    <= 1'b0;
      again   <= 1'b0;
      irq_out <= !irq_pol;
    end else begin
      req_q   <= irq_req;
      pend    <= pend_n;
      again   <= again_n;
      irq_out <= irq_pol ? pend_n : !pend_n;
    end
  end
endmodule

// File: rtl/host_attn_ctrl.sv
module host_attn_ctrl
  import hac_pkg::*;
#(
  parameter int          DATA_W      = 32,
  parameter int          SYNC_STAGES = 2,
  parameter int          RST_SYS_CYC = 5,
  parameter int          RST_TX_CYC  = 4,
  parameter logic [31:0] DEF_START   = 32'h00FF_FFF6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hw_reset_a,
  input  logic              attn_a,
  input  logic              port_wr_a,
  input  logic [DATA_W-1:0] port_data,
  input  logic              tx_tick,
  input  logic              core_busy,
  input  logic              irq_req,
  input  logic              irq_ack,
  input  logic              irq_pol,
  output logic              dev_reset,
  output logic              init_req,
  output logic              exec_req,
  output logic [DATA_W-1:0] req_addr,
  output logic              test_req,
  output logic [DATA_W-1:0] test_addr,
  output logic              irq_out
);
  localparam int NSYNC = 3;

  logic [NSYNC-1:0]  sync_q;
  logic              rst_s, attn_s, wr_s;
  logic              attn_q, attn_evt;
  logic              cmd_valid, soft_rst;
  logic [CODE_W-1:0] cmd_code;
  logic [DATA_W-1:0] cmd_addr, start_reg;

  hac_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_a ({port_wr_a, attn_a, hw_reset_a}),
    .q   (sync_q)
  );
  assign rst_s  = sync_q[0];
  assign attn_s = sync_q[1];
  assign wr_s   = sync_q[2];

  hac_reset_seq #(.SYS_CYC(RST_SYS_CYC), .TX_CYC(RST_TX_CYC)) u_rseq (
    .clk       (clk),
    .rst       (rst),
    .pin_sync  (rst_s),
    .tx_tick   (tx_tick),
    .dev_reset (dev_reset)
  );

  always_ff @(posedge clk) begin
    if (rst || dev_reset) attn_q <= 1'b0;
    else                  attn_q <= attn_s;
  end
  assign attn_evt = attn_q && !attn_s && !dev_reset;

  hac_port_dec #(.DW(DATA_W)) u_port (
    .clk       (clk),
    .rst       (rst),
    .clr       (dev_reset),
    .wr_sync   (wr_s),
    .data      (port_data),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_addr  (cmd_addr)
  );

  assign soft_rst = cmd_valid && (cmd_code == PCMD_SOFT_RST);

  always_ff @(posedge clk) begin
    if (rst || dev_reset) begin
      start_reg <= DATA_W'(DEF_START);
      test_req  <= 1'b0;
      test_addr <= '0;
    end else begin
      test_req <= 1'b0;
      if (cmd_valid && cmd_code == PCMD_SET_START) start_reg <= cmd_addr;
      if (cmd_valid && cmd_code == PCMD_SELF_TEST) begin
        test_req  <= 1'b1;
        test_addr <= cmd_addr;
      end
    end
  end

  hac_attn_seq #(.DW(DATA_W)) u_attn (
    .clk        (clk),
    .rst        (rst),
    .clr        (dev_reset),
    .soft_rst   (soft_rst),
    .attn_evt   (attn_evt),
    .core_busy  (core_busy),
    .start_addr (start_reg),
    .init_req   (init_req),
    .exec_req   (exec_req),
    .req_addr   (req_addr)
  );

  hac_irq_gen u_irq (
    .clk     (clk),
    .rst     (rst),
    .clr     (dev_reset),
    .irq_req (irq_req),
    .irq_ack (irq_ack),
    .irq_pol (irq_pol),
    .irq_out (irq_out)
  );
endmodule

// File: rtl/hac_checker.sv
module hac_checker #(
  parameter int RST_SYS_CYC = 5
) (
  input logic clk,
  input logic rst,
  input logic rst_sync,
  input logic dev_reset,
  input logic init_req,
  input logic exec_req,
  input logic test_req,
  input logic irq_ack,
  input logic irq_pol,
  input logic irq_out
);
  logic [7:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst || !rst_sync) hi_cnt <= '0;
    else if (hi_cnt != 8'hFF) hi_cnt <= hi_cnt + 1'b1;
  end

  assert_req_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
    !(init_req && exec_req));

  assert_init_single_R11: assert property (@(posedge clk) disable iff (rst)
    init_req |=> !init_req);

  assert_exec_single_R11: assert property (@(posedge clk) disable iff (rst)
    exec_req |=> !exec_req);

  assert_quiet_in_reset_R3: assert property (@(posedge clk) disable iff (rst)
    (dev_reset && $past(dev_reset)) |-> !(init_req || exec_req || test_req));

  assert_reset_min_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(dev_reset) |-> (hi_cnt >= 8'(RST_SYS_CYC)));

  assert_reset_release_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_sync) |=> !dev_reset);

  assert_ack_clears_R12: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> (irq_out != $past(irq_pol)));
endmodule

bind host_attn_ctrl hac_checker #(.RST_SYS_CYC(RST_SYS_CYC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rst_sync  (rst_s),
  .dev_reset (dev_reset),
  .init_req  (init_req),
  .exec_req  (exec_req),
  .test_req  (test_req),
  .irq_ack   (irq_ack),
  .irq_pol   (irq_pol),
  .irq_out   (irq_out)
);

// File: tb/host_attn_ctrl_test.sv
`timescale 1ns/1ps
module host_attn_ctrl_test;
  localparam logic [31:0] DEF = 32'h00FF_FFF6;

  logic clk = 1'b0, rst = 1'b1;
  logic hw_reset_a = 0, attn_a = 0, port_wr_a = 0, tx_tick = 0;
  logic core_busy = 0, irq_req = 0, irq_ack = 0, irq_pol = 1;
  logic [31:0] port_data = '0;
  logic dev_reset, init_req, exec_req, test_req, irq_out;
  logic [31:0] req_addr, test_addr;

  int checks = 0, errors = 0;
  int n_init = 0, n_exec = 0, n_test = 0, n_dev = 0, n_irq = 0;
  logic [31:0] last_init = '0, last_test = '0;
  logic prev_irq = 1'b0;

  always #10 clk = ~clk;

  host_attn_ctrl uut (
    .clk(clk), .rst(rst), .hw_reset_a(hw_reset_a), .attn_a(attn_a),
    .port_wr_a(port_wr_a), .port_data(port_data), .tx_tick(tx_tick),
    .core_busy(core_busy), .irq_req(irq_req), .irq_ack(irq_ack),
    .irq_pol(irq_pol), .dev_reset(dev_reset), .init_req(init_req),
    .exec_req(exec_req), .req_addr(req_addr), .test_req(test_req),
    .test_addr(test_addr), .irq_out(irq_out)
  );

  always @(posedge clk) begin
    #5;
    if (init_req) begin n_init++; last_init = req_addr; end
    if (exec_req) n_exec++;
    if (test_req) begin n_test++; last_test = test_addr; end
    if (dev_reset) n_dev++;
    if (irq_out == irq_pol && prev_irq != irq_pol) n_irq++;
    prev_irq = irq_out;
  end

  function automatic logic [31:0] exp_addr(input logic [31:0] word);
    return {word[31:4], 4'h0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic attn();
    attn_a = 1; cyc(2); attn_a = 0; cyc(6);
  endtask

  task automatic strobe(input logic [31:0] d);
    port_data = d; port_wr_a = 1; cyc(3); port_wr_a = 0; cyc(3);
  endtask

  task automatic port_cmd(input logic [31:0] w);
    strobe({16'($urandom), w[15:0]});
    strobe({w[31:16], 16'($urandom)});
    cyc(3);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
  end

  initial begin
    int i0, i1;
    logic [31:0] w, start;
    void'($urandom(32'd20240));
    cyc(3); rst = 0; cyc(2);
    chk("R13 dev_reset", dev_reset, 0);
    chk("R13 irq_out", irq_out, 0);
    chk("R13 requests", n_init + n_exec + n_test, 0);

    // R1: short reset pulse with plenty of ticks
    hw_reset_a = 1; tx_tick = 1; cyc(3); hw_reset_a = 0; tx_tick = 0; cyc(6);
    chk("R1 short pulse", n_dev, 0);

    // R2: long hold but only three ticks
    hw_reset_a = 1; cyc(3);
    for (int i = 0; i < 20; i++) begin tx_tick = (i < 3); cyc(1); end
    tx_tick = 0;
    chk("R2 three ticks", dev_reset, 0);
    tx_tick = 1; cyc(1); tx_tick = 0; cyc(3);
    chk("R2 fourth tick", dev_reset, 1);
    // R3: stimulus during reset ignored
    attn();
    port_cmd(32'h1234_5672);
    chk("R3 no request in reset", n_init + n_exec + n_test, 0);
    hw_reset_a = 0; cyc(5);
    chk("R2 release", dev_reset, 0);
    cyc(10);
    chk("R3 no auto start", n_init + n_exec, 0);

    // R4 level held high, then R5 first attention
    attn_a = 1; cyc(10);
    chk("R4 level high", n_init + n_exec, 0);
    attn_a = 0; cyc(6);
    chk("R5 init count", n_init, 1);
    chk("R5 default addr", last_init, DEF);

    // R6
    attn(); attn(); attn();
    chk("R6 exec count", n_exec, 3);
    chk("R6 no more init", n_init, 1);

    // R7: a single strobe carrying code 0 does nothing
    strobe(32'hFFFF_0000); cyc(3);
    i0 = n_init; i1 = n_exec; attn();
    chk("R7 one strobe inert", n_exec - i1, 1);
    chk("R7 one strobe no init", n_init - i0, 0);
    // second strobe completes the soft reset (R10)
    strobe(32'h0000_ABCD); cyc(3);
    attn();
    chk("R10 soft reset then init", n_init - i0, 1);
    chk("R10 default kept", last_init, DEF);

    // R8 random start addresses
    for (int k = 0; k < 6; k++) begin
      w = {$urandom} & 32'hFFFF_FFF0 | 32'h2;
      port_cmd(w);
      port_cmd(32'h0);
      i0 = n_init; attn();
      chk("R8 init count", n_init - i0, 1);
      chk("R8 loaded addr", last_init, exp_addr(w));
    end
    start = last_init;

    // R9 self-test
    w = {$urandom} & 32'hFFFF_FFF0 | 32'h1;
    i0 = n_test; port_cmd(w);
    chk("R9 test pulse", n_test - i0, 1);
    chk("R9 test addr", last_test, exp_addr(w));

    // R10 unknown code ignored
    port_cmd(32'hDEAD_BEE7);
    i0 = n_init; i1 = n_exec; attn();
    chk("R10 unknown code exec", n_exec - i1, 1);
    port_cmd(32'h0); attn();
    chk("R10 start kept", last_init, start);

    // R11 coalescing under busy
    core_busy = 1; i1 = n_exec; attn(); attn(); attn();
    chk("R11 held while busy", n_exec - i1, 0);
    core_busy = 0; cyc(4);
    chk("R11 one exec", n_exec - i1, 1);
    port_cmd(32'h0); core_busy = 1; i0 = n_init; i1 = n_exec;
    attn(); attn(); core_busy = 0; cyc(4);
    chk("R11 one init", n_init - i0, 1);
    chk("R11 no exec", n_exec - i1, 0);

    // R8 hardware reset restores default
    hw_reset_a = 1; cyc(3);
    for (int i = 0; i < 8; i++) begin tx_tick = 1; cyc(1); end
    tx_tick = 0; hw_reset_a = 0; cyc(6);
    attn();
    chk("R8 default after hw reset", last_init, DEF);

    // R12 interrupt, active high
    i0 = n_irq; irq_req = 1; cyc(2);
    chk("R12 active high", irq_out, 1);
    irq_req = 0; cyc(1); irq_req = 1; cyc(1); irq_req = 0; cyc(1);
    irq_ack = 1; cyc(1); irq_ack = 0;
    chk("R12 ack inactive", irq_out, 0);
    cyc(2);
    chk("R12 queued edge", irq_out, 1);
    irq_ack = 1; cyc(1); irq_ack = 0; cyc(2);
    chk("R12 edges", n_irq - i0, 2);
    chk("R12 cleared", irq_out, 0);

    // R12 active low with random pulses
    irq_pol = 0; rst = 1; cyc(2); rst = 0; cyc(1);
    chk("R13 inactive low-pol", irq_out, 1);
    for (int k = 0; k < 5; k++) begin
      irq_req = 1; cyc(1 + ($urandom % 3)); irq_req = 0; cyc(2);
      chk("R12 low active", irq_out, 0);
      irq_ack = 1; cyc(1); irq_ack = 0; cyc(1);
      chk("R12 low ack", irq_out, 1);
    end
    summary();
  end
endmodule